// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is the control front-end of a synchronous burst static memory, wrapped around a behavioural storage array with byte lanes. Every rising clock edge it samples an address, three chip selects, two burst-start strobes, an advance input, a global write enable, a byte-write enable with per-lane selects, and a sleep input. From these it decides whether the cycle starts a burst, continues one, holds it, or deselects the device. It also drives the per-lane array write strobes and returns the read word.

A burst covers four words that share every address bit above the two lowest. A 2-bit counter walks those four words in linear or interleaved order, and wraps back to the start without carrying upward. Read data comes out either in the cycle after the access (flow-through) or one clock later through an output register (pipelined). An output enable blanks the data without disturbing the burst. A clocked sleep request parks the device with its burst position intact, and a fixed recovery interval follows the release.

The controller has five states. S_DESEL is idle. S_READ and S_WRITE are active bursts. S_SLEEP is parked. S_WAKE is the recovery interval. The transitions are:
- Any start moves an active state to S_READ or S_WRITE.
- A rejected controller strobe moves an active state to S_DESEL.
- A second consecutive sleep sample moves an active state to S_SLEEP.
- A low sleep sample moves S_SLEEP to S_WAKE.
- When its countdown reaches zero, S_WAKE returns to the active state that was saved on entry to sleep.

Top module: `sbsram_ctrl`

## Requirements
- R1: With `cpu_stb_n` low and `sel_n` low, a read burst starts at `addr`. The write enables, `en_hi` and `en_lo_n` are ignored, and `wr_strobe` is 0 in that cycle.
- R2: With `ctl_stb_n` low (and no processor start), a burst starts only if `sel_n`=0, `en_hi`=1 and `en_lo_n`=0. Otherwise the device deselects: nothing is written, and `rd_oe` is 0 after the edge.
- R3: With no strobe active in S_READ or S_WRITE, `step_n`=0 advances the counter and keeps the burst direction. With `step_n`=1 the burst holds: a read repeats the same word and a write stores nothing.
- R4: Beat k of a burst started at address A uses the bits of A above bit 1 unchanged. Its low two bits are (A[1:0]+k) mod 4 when `ilv_order`=0, or A[1:0] XOR (k mod 4) when `ilv_order`=1. The fifth beat returns to the start address.
- R5: Lane i is data bits [8i+7:8i]. When `all_wr_n`=0, every lane is written. Otherwise, when `lane_wr_n`=0, lane i is written when `lane_sel_n[i]`=0. Otherwise the cycle is a read.
- R6: `wr_strobe` shows, within the current cycle, the lanes that the coming edge will write. The array stores `wdata` into those lanes at that edge.
- R7: With `flow_thru`=1, read data is valid after the access edge. With `flow_thru`=0, it is valid one edge later.
- R8: While `oe_n`=1, `rd_oe` and `rdata` are 0, and the burst position is not affected.
- R9: `sleep` sampled high on two consecutive edges raises `asleep` after the second edge. A one-cycle pulse has no effect. While asleep, no write strobe and no read data appear.
- R10: After `sleep` is sampled low, the block spends WAKE_CYC cycles in S_WAKE, where all inputs are ignored. It then resumes the saved burst at the same position.
- R11: After reset the block is in S_DESEL, with `rd_oe`=0, `rdata`=0, `wr_strobe`=0 and `asleep`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address loaded on a burst start |
| sel_n | input | 1 | Primary chip select, active low |
| en_hi | input | 1 | Extra chip select, active high, used with controller strobe |
| en_lo_n | input | 1 | Extra chip select, active low, used with controller strobe |
| cpu_stb_n | input | 1 | Processor burst-start strobe, active low |
| ctl_stb_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| flow_thru | input | 1 | Output mode: 1 flow-through, 0 pipelined |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rd_oe | output | 1 | Read data is being driven |
| wr_strobe | output | LANES | Array lane write strobes for the coming edge |
| asleep | output | 1 | Device is in sleep |

## Verification
Several rules are checked on every cycle by embedded properties:
- The burst counter steps by exactly one on an advance, and holds its position when neither a start nor an advance arrives.
- A processor-strobe start never raises a write strobe.
- A sleep or wake state never writes.
- Two consecutive sleep samples always land in S_SLEEP.
- The wake countdown is never cut short.
- The pipelined output always lags the access by one edge.

Other behaviour can only be shown by the bench scenarios. Those scenarios cover:
- that the addresses of linear and interleaved bursts from every start offset match the arithmetic, including the wrap back to the start;
- that byte-lane writes leave the unselected lanes intact;
- that rejected starts leave memory unchanged;
- that a burst interrupted by sleep resumes at the right word.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [2:0] {
        S_DESEL,
        S_READ,
        S_WRITE,
        S_SLEEP,
        S_WAKE
    } ctl_state_t;

    // Low two address bits of a beat, given the start offset and the count.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/sbsram_burst_ctr.sv
module sbsram_burst_ctr
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;

    always_comb begin
        base_d = load ? ext_addr : base_q;
        if (load) begin
            cnt_d = 2'd0;
        end else if (step) begin
            cnt_d = cnt_q + 2'd1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    assign nxt_addr = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], cnt_d, ilv)};
    assign cur_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_q, ilv)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // R3: an advance moves the count by exactly one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R3: with no start and no advance the burst position holds
    a_r3_hold_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> ($stable(cnt_q) && $stable(base_q)));

    // R4: a start loads the external address as the first beat
    a_r4_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (base_q == $past(ext_addr) && cnt_q == 2'd0));

endmodule

// File: rtl/sbsram_fsm.sv
module sbsram_fsm
    import sbsram_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int WAKE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             sel_n,
    input  logic             en_hi,
    input  logic             en_lo_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             sleep,
    output logic             load,
    output logic             step,
    output logic [LANES-1:0] wr_lanes,
    output logic             rd_q,
    output logic             asleep
);

    localparam int WCW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [WCW-1:0] WLOAD = WCW'(WAKE_CYC - 1);

    ctl_state_t     state_q, state_d, run_nxt, resume_q;
    logic [WCW-1:0] wcnt_q;
    logic           sleep_q;
    logic           active, in_burst, go_cpu, ctl_hit, ctl_sel, cont;
    logic           wr_start, rd_now, wr_req;
    logic [LANES-1:0] lanes_dec;

    // Command decode for the current cycle
    always_comb begin
        active   = (state_q == S_DESEL) || (state_q == S_READ) || (state_q == S_WRITE);
        in_burst = (state_q == S_READ) || (state_q == S_WRITE);
        go_cpu   = active && !cpu_stb_n && !sel_n;
        ctl_hit  = active && !go_cpu && !ctl_stb_n;
        ctl_sel  = ctl_hit && !sel_n && en_hi && !en_lo_n;
        cont     = active && !go_cpu && !ctl_hit && in_burst;
        step     = cont && !step_n;
        load     = go_cpu || ctl_sel;

        if (!all_wr_n) begin
            lanes_dec = '1;
        end else if (!lane_wr_n) begin
            lanes_dec = ~lane_sel_n;
        end else begin
            lanes_dec = '0;
        end
        wr_req   = |lanes_dec;
        wr_start = ctl_sel && wr_req;

        if (wr_start || ((state_q == S_WRITE) && step)) begin
            wr_lanes = lanes_dec;
        end else begin
            wr_lanes = '0;
        end

        rd_now = go_cpu || (ctl_sel && !wr_req) || ((state_q == S_READ) && cont);
    end

    // Next-state selection
    always_comb begin
        run_nxt = state_q;
        if (load) begin
            run_nxt = wr_start ? S_WRITE : S_READ;
        end else if (ctl_hit) begin
            run_nxt = S_DESEL;
        end

        unique case (state_q)
            S_DESEL, S_READ, S_WRITE: state_d = (sleep && sleep_q) ? S_SLEEP : run_nxt;
            S_SLEEP:                  state_d = sleep ? S_SLEEP : S_WAKE;
            S_WAKE:                   state_d = (wcnt_q == '0) ? resume_q : S_WAKE;
            default:                  state_d = S_DESEL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and bookkeeping of the sleep path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_q  <= 1'b0;
            rd_q     <= 1'b0;
            resume_q <= S_DESEL;
            wcnt_q   <= WLOAD;
        end else begin
            sleep_q <= sleep;
            rd_q    <= rd_now;
            if (active && (state_d == S_SLEEP)) begin
                resume_q <= run_nxt;
            end
            if (state_q == S_SLEEP) begin
                wcnt_q <= WLOAD;
            end else if ((state_q == S_WAKE) && (wcnt_q != '0)) begin
                wcnt_q <= wcnt_q - 1'b1;
            end
        end
    end

    assign asleep = (state_q == S_SLEEP);

    // R1: a processor-strobe start never writes
    a_r1_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cpu_stb_n && !sel_n) |-> (wr_lanes == '0));

    // R2: a rejected controller strobe produces no read access
    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cpu_stb_n && !ctl_stb_n && !en_hi) |=> !rd_q);

    // R9: two consecutive sleep samples enter the sleep state
    a_r9_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sleep && sleep_q) |=> (state_q == S_SLEEP));

    // R9: nothing is written outside the active states
    a_r9_no_write_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (wr_lanes == '0));

    // R10: the recovery countdown is never cut short
    a_r10_wake_len: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_WAKE) && (wcnt_q != '0)) |=> (state_q == S_WAKE));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rword
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/sbsram_outpath.sv
module sbsram_outpath #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_thru,
    input  logic          oe_n,
    input  logic          rd_q,
    input  logic [DW-1:0] mem_word,
    output logic [DW-1:0] rdata,
    output logic          rd_oe
);

    logic          pipe_vld;
    logic [DW-1:0] pipe_dat;
    logic          src_vld;
    logic [DW-1:0] src_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_vld <= 1'b0;
            pipe_dat <= '0;
        end else begin
            pipe_vld <= rd_q;
            pipe_dat <= mem_word;
        end
    end

    always_comb begin
        src_vld = flow_thru ? rd_q : pipe_vld;
        src_dat = flow_thru ? mem_word : pipe_dat;
        rd_oe   = src_vld && !oe_n;
        rdata   = rd_oe ? src_dat : '0;
    end

    // R7: in pipelined mode the data follows the access by one edge
    a_r7_pipe_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && !oe_n) |-> (rd_oe == $past(rd_q)));

    // R8: a deasserted output enable blanks the bus
    a_r8_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rd_oe && rdata == '0));

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 2,
    parameter int LANE_W   = 8,
    parameter int WAKE_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     sel_n,
    input  logic                     en_hi,
    input  logic                     en_lo_n,
    input  logic                     cpu_stb_n,
    input  logic                     ctl_stb_n,
    input  logic                     step_n,
    input  logic                     all_wr_n,
    input  logic                     lane_wr_n,
    input  logic [LANES-1:0]         lane_sel_n,
    input  logic                     ilv_order,
    input  logic                     flow_thru,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rd_oe,
    output logic [LANES-1:0]         wr_strobe,
    output logic                     asleep
);

    localparam int DW = LANES * LANE_W;

    logic              load, step, rd_q;
    logic [ADDR_W-1:0] nxt_addr, cur_addr;
    logic [DW-1:0]     mem_word;

    sbsram_fsm #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .sel_n      (sel_n),
        .en_hi      (en_hi),
        .en_lo_n    (en_lo_n),
        .step_n     (step_n),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .sleep      (sleep),
        .load       (load),
        .step       (step),
        .wr_lanes   (wr_strobe),
        .rd_q       (rd_q),
        .asleep     (asleep)
    );

    sbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .ilv      (ilv_order),
        .ext_addr (addr),
        .nxt_addr (nxt_addr),
        .cur_addr (cur_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (wr_strobe),
        .waddr (nxt_addr),
        .wdata (wdata),
        .raddr (cur_addr),
        .rword (mem_word)
    );

    sbsram_outpath #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .oe_n      (oe_n),
        .rd_q      (rd_q),
        .mem_word  (mem_word),
        .rdata     (rdata),
        .rd_oe     (rd_oe)
    );

endmodule

// File: tb/test_sbsram_ctrl.sv
`timescale 1ns/1ps
module test_sbsram_ctrl;

    localparam int AW = 6;
    localparam int LN = 2;
    localparam int LW = 8;
    localparam int DW = LN * LW;
    localparam int WK = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b1, en_hi = 1'b1, en_lo_n = 1'b0;
    logic          cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
    logic          all_wr_n = 1'b1, lane_wr_n = 1'b1;
    logic [LN-1:0] lane_sel_n = '1;
    logic          ilv_order = 1'b0, flow_thru = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_oe, asleep;
    logic [LN-1:0] wr_strobe;

    logic [DW-1:0] mdl [1 << AW];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sbsram_ctrl #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .WAKE_CYC(WK)) i_sbsram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .en_hi(en_hi),
        .en_lo_n(en_lo_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
        .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .ilv_order(ilv_order), .flow_thru(flow_thru),
        .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe),
        .wr_strobe(wr_strobe), .asleep(asleep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R4: expected address of beat k
    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input logic ilv, input int k);
        logic [1:0] kk;
        logic [1:0] lo;
        kk = 2'(k % 4);
        lo = ilv ? (a[1:0] ^ kk) : 2'((a[1:0] + kk) % 4);
        return {a[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] dpat(input int s, input int k);
        return DW'(s * 911 + k * 97 + 16'h1234);
    endfunction

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = '1;
        sel_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0;
    endtask

    // Write burst through the controller strobe (R2, R3, R5, R6)
    task automatic write_burst(input logic [AW-1:0] a, input logic ilv, input logic use_gw,
                               input logic [LN-1:0] bsel_n, input int seed);
        logic [LN-1:0] lanes;
        logic [AW-1:0] ea;
        ilv_order = ilv;
        lanes = use_gw ? '1 : ~bsel_n;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            if (k == 0) begin
                ctl_stb_n = 1'b0; addr = a;
            end else begin
                step_n = 1'b0;
            end
            if (use_gw) all_wr_n = 1'b0;
            else begin lane_wr_n = 1'b0; lane_sel_n = bsel_n; end
            wdata = dpat(seed, k);
            #1;
            chk("R5/R6 write lanes", 32'(wr_strobe), 32'(lanes));
            ea = exp_addr(a, ilv, k);
            for (int i = 0; i < LN; i++)
                if (lanes[i]) mdl[ea][i*LW +: LW] = wdata[i*LW +: LW];
            @(posedge clk);
        end
        @(negedge clk);
        idle();
        #1;
        chk("R3 write hold no strobe", 32'(wr_strobe), 32'd0);
    endtask

    // Read burst through the processor strobe, five beats (R1, R3, R4, R7, R8)
    task automatic read_burst(input logic [AW-1:0] a, input logic ilv, input int off);
        int b;
        ilv_order = ilv;
        @(negedge clk);
        idle();
        cpu_stb_n = 1'b0; addr = a;
        @(posedge clk);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            idle();
            b = flow_thru ? j : j - 1;
            oe_n = (b == off);
            #1;
            if (b >= 0 && b <= 4) begin
                if (b == off) begin
                    chk("R8 oe blank rd_oe", 32'(rd_oe), 32'd0);
                    chk("R8 oe blank rdata", 32'(rdata), 32'd0);
                end else begin
                    chk("R7 rd_oe", 32'(rd_oe), 32'd1);
                    chk("R4 beat data", 32'(rdata), 32'(mdl[exp_addr(a, ilv, b)]));
                end
            end
            step_n = (j < 4) ? 1'b0 : 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        oe_n = 1'b0;
        idle();
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 rd_oe", 32'(rd_oe), 32'd0);
        chk("R11 rdata", 32'(rdata), 32'd0);
        chk("R11 wr_strobe", 32'(wr_strobe), 32'd0);
        chk("R11 asleep", 32'(asleep), 32'd0);
        rst_n = 1'b1;

        // Fill the whole array with global-write bursts
        for (int q = 0; q < (1 << AW) / 4; q++)
            write_burst(AW'(q * 4), 1'b0, 1'b1, '1, q);

        // Sweep output mode, burst order and start offset
        for (int f = 0; f < 2; f++)
            for (int o = 0; o < 2; o++)
                for (int s = 0; s < 4; s++) begin
                    flow_thru = f[0];
                    a = AW'((f * 2 + o) * 8 + 4 + s);
                    write_burst(a, o[0], 1'b1, '1, 100 + f * 8 + o * 4 + s);
                    read_burst(a, o[0], -1);
                    read_burst(a, ~o[0], (s == 1) ? 2 : -1);
                end

        // R5: byte-lane writes keep the other lane
        flow_thru = 1'b1;
        write_burst(6'h30, 1'b0, 1'b0, 2'b10, 300);
        write_burst(6'h34, 1'b1, 1'b0, 2'b01, 301);
        read_burst(6'h30, 1'b0, -1);
        read_burst(6'h35, 1'b1, -1);
        // R5: qualifier low with no lane selected is a read
        @(negedge clk);
        idle(); ctl_stb_n = 1'b0; addr = 6'h31; lane_wr_n = 1'b0; lane_sel_n = '1;
        #1 chk("R5 no lane no write", 32'(wr_strobe), 32'd0);
        @(posedge clk);
        @(negedge clk); idle(); #1;
        chk("R5 no lane reads", 32'(rdata), 32'(mdl[6'h31]));

        // R1: processor strobe ignores write enables and extra selects
        @(negedge clk);
        idle(); cpu_stb_n = 1'b0; addr = 6'h32; all_wr_n = 1'b0; lane_wr_n = 1'b0;
        lane_sel_n = '0; en_hi = 1'b0; en_lo_n = 1'b1; wdata = 16'hDEAD;
        #1 chk("R1 no write strobe", 32'(wr_strobe), 32'd0);
        @(posedge clk);
        @(negedge clk); idle(); #1;
        chk("R1 read starts", 32'(rd_oe), 32'd1);
        chk("R1 read data", 32'(rdata), 32'(mdl[6'h32]));

        // R2: rejected controller strobes deselect
        for (int v = 0; v < 3; v++) begin
            @(negedge clk);
            idle(); ctl_stb_n = 1'b0; addr = 6'h33; all_wr_n = 1'b0; wdata = 16'hBEEF;
            if (v == 0) en_hi = 1'b0;
            if (v == 1) en_lo_n = 1'b1;
            if (v == 2) sel_n = 1'b1;
            #1 chk("R2 deselect no write", 32'(wr_strobe), 32'd0);
            @(posedge clk);
            @(negedge clk); idle(); step_n = 1'b0; #1;
            chk("R2 deselect no drive", 32'(rd_oe), 32'd0);
            chk("R2 advance ignored when deselected", 32'(wr_strobe), 32'd0);
            @(posedge clk);
        end
        read_burst(6'h33, 1'b0, -1);

        // R9: one-cycle sleep pulse has no effect
        @(negedge clk); sleep = 1'b1;
        @(negedge clk); sleep = 1'b0;
        @(negedge clk); #1;
        chk("R9 pulse ignored", 32'(asleep), 32'd0);

        // R9/R10: sleep in the middle of a read burst
        flow_thru = 1'b1; ilv_order = 1'b0;
        @(negedge clk); idle(); cpu_stb_n = 1'b0; addr = 6'h21;
        @(posedge clk);
        @(negedge clk); idle(); step_n = 1'b0; sleep = 1'b1; #1;
        chk("R9 beat0 before sleep", 32'(rdata), 32'(mdl[6'h21]));
        @(posedge clk);
        @(negedge clk); idle(); #1;
        chk("R9 not yet asleep", 32'(asleep), 32'd0);
        chk("R9 beat1 before sleep", 32'(rdata), 32'(mdl[6'h22]));
        @(posedge clk);
        @(negedge clk); #1;
        chk("R9 asleep after two samples", 32'(asleep), 32'd1);
        idle(); ctl_stb_n = 1'b0; addr = 6'h21; all_wr_n = 1'b0; wdata = 16'hA5A5; #1;
        chk("R9 no write asleep", 32'(wr_strobe), 32'd0);
        @(posedge clk);
        @(negedge clk); #1;
        chk("R9 no read asleep", 32'(rd_oe), 32'd0);
        sleep = 1'b0;
        @(posedge clk);
        for (int w = 0; w < WK; w++) begin
            @(negedge clk); #1;
            chk("R10 wake not asleep", 32'(asleep), 32'd0);
            chk("R10 wake ignores write", 32'(wr_strobe), 32'd0);
            @(posedge clk);
        end
        @(negedge clk); idle(); step_n = 1'b0;
        @(posedge clk);
        @(negedge clk); idle(); #1;
        chk("R10 resumed rd_oe", 32'(rd_oe), 32'd1);
        chk("R10 resumed beat2", 32'(rdata), 32'(mdl[6'h23]));
        read_burst(6'h20, 1'b0, -1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule